// File: doc/BRIEF.md
# Branch Resolution and Flush Controller

This block makes the next-fetch decision for a three-stage in-order RV32I pipeline whose stages are IF/ID, EX and WB. Each cycle it receives the control-flow class of the instruction in EX, the instruction's compare condition and its operands. The compare operands arrive as a 33-bit zero-extended difference together with the sign bits of both operands. From these it computes the address to fetch next. A redirect happens only when the instruction in EX is a live jump or a branch whose condition holds, and only when the target is aligned. There is no prediction, so every redirect is resolved at the end of EX.

After a redirect, two wrong-path instructions are already in flight. The block squashes them with a registered flush. The IF/ID slot is killed in the cycle after the redirect, and the EX slot is killed in the cycle after that. While the EX slot is killed, its instruction cannot redirect fetch or raise a fault. A jump or taken branch whose target is misaligned does not redirect; it raises a fault flag instead.

Top module: `brx_redirect_ctl`

## Requirements
- R1: After reset, both flush outputs (`kill_ifid`, `kill_ex`) are 0.
- R2: When `ex_kind` is 0 (no control transfer), `taken` and `ill_branch` are 0 and `next_pc` equals `fetch_pc + 4`.
- R3: When `ex_kind` is 1 (jal) and the EX slot is live, `next_pc` equals `ex_pc + ex_imm` and `taken` is 1.
- R4: When `ex_kind` is 2 (jalr) and the EX slot is live, the target is `ex_op1 + ex_imm` with bit 0 forced to 0.
- R5: When `ex_kind` is 3 (branch), `ex_cond` 3'b000 is taken when `ex_diff` is all zero, and 3'b001 is taken when it is nonzero.
- R6: `ex_cond` 3'b100 is taken when operand 1 is less than operand 2 as signed numbers, and 3'b101 is taken otherwise. The signed result is derived as `ex_diff[32] ^ ex_op1[31] ^ ex_op2_msb`.
- R7: `ex_cond` 3'b110 is taken when the borrow bit `ex_diff[32]` is 1, and 3'b111 is taken when it is 0.
- R8: `ex_cond` values 3'b010 and 3'b011 never cause a branch to be taken.
- R9: A transfer whose target has either of bits [1:0] set raises `ill_branch`, keeps `taken` at 0 and leaves `next_pc` at `fetch_pc + 4`.
- R10: `kill_ifid` is 1 in exactly the cycle after `taken` is 1, and `kill_ex` is 1 in the cycle after `kill_ifid` is 1.
- R11: While `kill_ex` is 1, `taken` and `ill_branch` are 0 and `next_pc` is `fetch_pc + 4`, whatever the EX inputs are.
- R12: A redirect in the cycle after an earlier redirect is still taken, and it restarts the two-slot squash. `kill_ifid` is 1 for two cycles in a row, and `kill_ex` follows it one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| ex_kind | input | 2 | EX class: 0 none, 1 jal, 2 jalr, 3 branch |
| ex_cond | input | 3 | Branch compare code (funct3 coding) |
| ex_pc | input | 32 | Address of the EX instruction |
| ex_imm | input | 32 | Sign-extended immediate of the EX instruction |
| ex_op1 | input | 32 | First register operand |
| ex_op2_msb | input | 1 | Sign bit of the second register operand |
| ex_diff | input | 33 | Zero-extended `op1 - op2`, bit 32 is the borrow |
| next_pc | output | 32 | Address to fetch next |
| taken | output | 1 | A redirect happens this cycle |
| ill_branch | output | 1 | A transfer target is misaligned |
| kill_ifid | output | 1 | Squash the IF/ID slot |
| kill_ex | output | 1 | Squash the EX slot |

## Verification
`next_pc`, `taken` and `ill_branch` are combinational, so they are due in the same cycle as the EX inputs. `kill_ifid` is due one clock edge after a redirect and `kill_ex` two clock edges after. The bench drives the EX inputs on the falling edge. In the same step it computes an expected item that carries the flush values implied by the redirects of the previous two steps. The monitor samples the outputs 2 ns after that falling edge, so registered outputs have settled from the preceding rising edge and combinational outputs reflect the new inputs.

// File: rtl/brx_pkg.sv
package brx_pkg;

   typedef enum logic [1:0] {
      CF_NONE = 2'd0,
      CF_JAL  = 2'd1,
      CF_JALR = 2'd2,
      CF_BR   = 2'd3
   } cf_kind_e;

   localparam logic [2:0] CC_EQ  = 3'b000;
   localparam logic [2:0] CC_NE  = 3'b001;
   localparam logic [2:0] CC_LT  = 3'b100;
   localparam logic [2:0] CC_GE  = 3'b101;
   localparam logic [2:0] CC_LTU = 3'b110;
   localparam logic [2:0] CC_GEU = 3'b111;

endpackage

// File: rtl/brx_cond_eval.sv
module brx_cond_eval #(
   parameter int XLEN = 32
) (
   input  logic [2:0]    cond,
   input  logic [XLEN:0] diff,
   input  logic          a_msb,
   input  logic          b_msb,
   output logic          hit
);
   import brx_pkg::*;

   logic is_zero, lt_u, lt_s;

   always_comb begin
      is_zero = (diff == '0);
      lt_u    = diff[XLEN];
      lt_s    = diff[XLEN] ^ a_msb ^ b_msb;
      unique case (cond)
         CC_EQ:   hit = is_zero;
         CC_NE:   hit = !is_zero;
         CC_LT:   hit = lt_s;
         CC_GE:   hit = !lt_s;
         CC_LTU:  hit = lt_u;
         CC_GEU:  hit = !lt_u;
         default: hit = 1'b0;
      endcase
   end

   always_comb begin
      a_r8_reserved_cond: assert (!(hit && (cond == 3'b010 || cond == 3'b011)));
   end
endmodule

// File: rtl/brx_target_gen.sv
module brx_target_gen #(
   parameter int XLEN        = 32,
   parameter int ALIGN_BYTES = 4
) (
   input  logic [1:0]      kind,
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] imm,
   input  logic [XLEN-1:0] op1,
   output logic [XLEN-1:0] target,
   output logic            misaligned
);
   import brx_pkg::*;

   localparam int AL_BITS = $clog2(ALIGN_BYTES);

   logic [XLEN-1:0] rel_sum, reg_sum;

   always_comb begin
      rel_sum = pc + imm;
      reg_sum = op1 + imm;
      if (cf_kind_e'(kind) == CF_JALR) target = {reg_sum[XLEN-1:1], 1'b0};
      else                             target = rel_sum;
   end

   generate
      if (AL_BITS == 0) begin : g_no_align
         assign misaligned = 1'b0;
      end else begin : g_align
         assign misaligned = |target[AL_BITS-1:0];
      end
   endgenerate

   always_comb begin
      a_r4_jalr_even: assert (!(cf_kind_e'(kind) == CF_JALR && target[0]));
   end
endmodule

// File: rtl/brx_kill_pipe.sv
module brx_kill_pipe #(
   parameter int SLOTS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   output logic [SLOTS-1:0] kill
);
   logic [SLOTS-1:0] kill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) kill_q[0] <= 1'b0;
      else        kill_q[0] <= fire;
   end

   generate
      for (genvar i = 1; i < SLOTS; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) kill_q[i] <= 1'b0;
            else        kill_q[i] <= kill_q[i-1];
         end

         a_r10_shift: assert property (@(posedge clk) disable iff (!rst_n)
            kill_q[i-1] |=> kill_q[i]);
      end
   endgenerate

   assign kill = kill_q;

   a_r12_restart: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> kill_q[0]);
endmodule

// File: rtl/brx_redirect_ctl.sv
module brx_redirect_ctl #(
   parameter int XLEN        = 32,
   parameter int PC_STEP     = 4,
   parameter int ALIGN_BYTES = 4,
   parameter int KILL_SLOTS  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XLEN-1:0] fetch_pc,
   input  logic [1:0]      ex_kind,
   input  logic [2:0]      ex_cond,
   input  logic [XLEN-1:0] ex_pc,
   input  logic [XLEN-1:0] ex_imm,
   input  logic [XLEN-1:0] ex_op1,
   input  logic            ex_op2_msb,
   input  logic [XLEN:0]   ex_diff,
   output logic [XLEN-1:0] next_pc,
   output logic            taken,
   output logic            ill_branch,
   output logic            kill_ifid,
   output logic            kill_ex
);
   import brx_pkg::*;

   localparam logic [XLEN-1:0] STEP_W = XLEN'(PC_STEP);

   generate
      if (XLEN < 8)
         begin : g_bad_xlen  $error("XLEN too small");  end
      if (ALIGN_BYTES != 1 && ALIGN_BYTES != 2 && ALIGN_BYTES != 4)
         begin : g_bad_align $error("ALIGN_BYTES must be 1, 2 or 4"); end
      if (KILL_SLOTS != 2)
         begin : g_bad_slots $error("pipeline squashes exactly two slots"); end
      if (PC_STEP % ALIGN_BYTES != 0)
         begin : g_bad_step  $error("PC_STEP must keep alignment"); end
   endgenerate

   logic            cond_hit, misaligned, wants, live;
   logic [XLEN-1:0] target, seq_pc;
   logic [KILL_SLOTS-1:0] kill_v;
   cf_kind_e        kind;

   assign kind = cf_kind_e'(ex_kind);

   brx_cond_eval #(.XLEN(XLEN)) u_cond (
      .cond  (ex_cond),
      .diff  (ex_diff),
      .a_msb (ex_op1[XLEN-1]),
      .b_msb (ex_op2_msb),
      .hit   (cond_hit)
   );

   brx_target_gen #(.XLEN(XLEN), .ALIGN_BYTES(ALIGN_BYTES)) u_tgt (
      .kind       (ex_kind),
      .pc         (ex_pc),
      .imm        (ex_imm),
      .op1        (ex_op1),
      .target     (target),
      .misaligned (misaligned)
   );

   brx_kill_pipe #(.SLOTS(KILL_SLOTS)) u_kill (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (taken),
      .kill  (kill_v)
   );

   assign kill_ifid = kill_v[0];
   assign kill_ex   = kill_v[KILL_SLOTS-1];

   always_comb begin
      seq_pc = fetch_pc + STEP_W;
      unique case (kind)
         CF_JAL, CF_JALR: wants = 1'b1;
         CF_BR:           wants = cond_hit;
         default:         wants = 1'b0;
      endcase
      live       = !kill_ex;
      taken      = live && wants && !misaligned;
      ill_branch = live && wants && misaligned;
      next_pc    = taken ? target : seq_pc;
   end

   always_comb begin
      a_r9_exclusive: assert (!(taken && ill_branch));
   end

   a_r2_idle_seq: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_kind == 2'd0) |-> (!taken && !ill_branch && next_pc == fetch_pc + STEP_W));

   a_r11_killed_inert: assert property (@(posedge clk) disable iff (!rst_n)
      kill_ex |-> (!taken && !ill_branch && next_pc == fetch_pc + STEP_W));

   a_r10_ifid_after_taken: assert property (@(posedge clk) disable iff (!rst_n)
      taken |=> kill_ifid);

   a_r10_ifid_only_after_taken: assert property (@(posedge clk) disable iff (!rst_n)
      !taken |=> !kill_ifid);

   a_r10_ex_after_ifid: assert property (@(posedge clk) disable iff (!rst_n)
      kill_ifid |=> kill_ex);
endmodule

// File: tb/brx_redirect_ctl_tb.sv
module brx_redirect_ctl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0, ex_pc = '0, ex_imm = '0, ex_op1 = '0;
   logic [1:0]  ex_kind = '0;
   logic [2:0]  ex_cond = '0;
   logic        ex_op2_msb = 1'b0;
   logic [32:0] ex_diff = '0;
   logic [31:0] next_pc;
   logic        taken, ill_branch, kill_ifid, kill_ex;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] npc;
      logic        tk, il, k1, k2;
      string       rq;
   } item_t;
   item_t sbq[$];
   logic m_k1 = 1'b0, m_k2 = 1'b0;

   always #4 clk = ~clk;

   brx_redirect_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .ex_kind(ex_kind),
      .ex_cond(ex_cond), .ex_pc(ex_pc), .ex_imm(ex_imm), .ex_op1(ex_op1),
      .ex_op2_msb(ex_op2_msb), .ex_diff(ex_diff), .next_pc(next_pc),
      .taken(taken), .ill_branch(ill_branch), .kill_ifid(kill_ifid),
      .kill_ex(kill_ex)
   );

   task automatic step(input logic [1:0] k, input logic [2:0] c,
                       input logic [31:0] pc, input logic [31:0] imm,
                       input logic [31:0] o1, input logic [31:0] o2,
                       input string rq);
      logic        hit, want, mis;
      logic [31:0] tgt;
      item_t       it;
      @(negedge clk);
      fetch_pc   = pc + 32'd8;
      ex_kind    = k;
      ex_cond    = c;
      ex_pc      = pc;
      ex_imm     = imm;
      ex_op1     = o1;
      ex_op2_msb = o2[31];
      ex_diff    = {1'b0, o1} - {1'b0, o2};
      case (c)
         3'b000:  hit = (o1 == o2);
         3'b001:  hit = (o1 != o2);
         3'b100:  hit = ($signed(o1) <  $signed(o2));
         3'b101:  hit = ($signed(o1) >= $signed(o2));
         3'b110:  hit = (o1 <  o2);
         3'b111:  hit = (o1 >= o2);
         default: hit = 1'b0;
      endcase
      want = (k == 2'd1) || (k == 2'd2) || (k == 2'd3 && hit);
      tgt  = (k == 2'd2) ? ((o1 + imm) & ~32'd1) : (pc + imm);
      mis  = (tgt[1:0] != 2'b00);
      it.tk  = want && !m_k2 && !mis;
      it.il  = want && !m_k2 && mis;
      it.npc = it.tk ? tgt : (pc + 32'd12);
      it.k1  = m_k1;
      it.k2  = m_k2;
      it.rq  = rq;
      sbq.push_back(it);
      m_k2 = m_k1;
      m_k1 = it.tk;
   endtask

   task automatic idle(input string rq);
      step(2'd0, 3'b000, 32'h0000_0800, 32'd0, 32'd0, 32'd0, rq);
   endtask

   always @(negedge clk) begin
      #2;
      while (sbq.size() > 0) begin
         item_t e;
         e = sbq.pop_front();
         checks++;
         if (next_pc !== e.npc || taken !== e.tk || ill_branch !== e.il ||
             kill_ifid !== e.k1 || kill_ex !== e.k2) begin
            errors++;
            $display("FAIL %s: got npc=%h tk=%b il=%b kif=%b kex=%b exp npc=%h tk=%b il=%b kif=%b kex=%b",
                     e.rq, next_pc, taken, ill_branch, kill_ifid, kill_ex,
                     e.npc, e.tk, e.il, e.k1, e.k2);
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      checks++;
      if (kill_ifid !== 1'b0 || kill_ex !== 1'b0) begin
         errors++;
         $display("FAIL R1: got kif=%b kex=%b exp 0 0", kill_ifid, kill_ex);
      end
      idle("R2");
      step(2'd1, 3'b000, 32'h100, 32'h40, 32'd0, 32'd0, "R3");
      idle("R10");
      step(2'd1, 3'b000, 32'h200, 32'h10, 32'd0, 32'd0, "R11");
      idle("R10");
      step(2'd2, 3'b000, 32'h180, 32'h4, 32'h1001, 32'd0, "R4");
      idle("R10");
      idle("R10");
      step(2'd2, 3'b000, 32'h180, 32'h6, 32'h2000, 32'd0, "R9");
      step(2'd1, 3'b000, 32'h300, 32'h22, 32'd0, 32'd0, "R9");
      step(2'd3, 3'b000, 32'h400, 32'h20, 32'd5, 32'd5, "R5");
      idle("R10");
      idle("R10");
      step(2'd3, 3'b000, 32'h400, 32'h20, 32'd5, 32'd6, "R5");
      step(2'd3, 3'b001, 32'h400, 32'h20, 32'd5, 32'd6, "R5");
      idle("R10");
      idle("R10");
      step(2'd3, 3'b100, 32'h440, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 32'd1, "R6");
      idle("R10");
      idle("R10");
      step(2'd3, 3'b110, 32'h440, 32'h30, 32'hFFFF_FFFF, 32'd1, "R7");
      step(2'd3, 3'b101, 32'h440, 32'h30, 32'hFFFF_FFFF, 32'd1, "R6");
      step(2'd3, 3'b111, 32'h440, 32'h30, 32'hFFFF_FFFF, 32'd1, "R7");
      idle("R10");
      idle("R10");
      step(2'd3, 3'b010, 32'h480, 32'h30, 32'd7, 32'd7, "R8");
      step(2'd3, 3'b011, 32'h480, 32'h30, 32'd7, 32'd9, "R8");
      step(2'd3, 3'b001, 32'h500, 32'h40, 32'd1, 32'd2, "R12");
      step(2'd3, 3'b100, 32'h504, 32'h80, 32'd1, 32'd2, "R12");
      idle("R12");
      idle("R12");
      idle("R12");
      step(2'd3, 3'b101, 32'h600, 32'h10, 32'h7FFF_FFFF, 32'h8000_0000, "R6");
      step(2'd3, 3'b110, 32'h600, 32'h10, 32'h7FFF_FFFF, 32'h8000_0000, "R7");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule